// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide host side of a three-channel interval timer. A host writes control words to address 3 and count bytes to addresses 0 to 2, and it reads bytes back from addresses 0 to 2. The block turns those byte accesses into a 16-bit load strobe and load value for each counter channel. It also returns the live count, a frozen count snapshot, or a status snapshot, in the order the access rules require. The counters themselves sit outside the block. Each one presents its live count and output level, and each one takes the counting mode and the BCD flag from this block.

For each channel the block keeps an access mode, a counting mode, a BCD flag, a write byte pointer with its held low byte, a read byte pointer, a count snapshot and its release state, and a status snapshot. Control words either reprogram one channel, freeze the count of one channel, or, as a read-back command, freeze the count and/or status of any subset of the channels. A read strobe is honoured only when no write strobe is present in the same cycle. The read data is combinational in the strobed cycle and is zero whenever no read is in progress.

Top module: `tmr_host_if`

## Requirements
- R1: After reset no load strobe is active, every channel uses word access with counting mode 0 and BCD flag 0, no snapshot is held, and a live read returns the low byte first.
- R2: A control word with channel select 0 to 2 and a non-zero access field reprograms that channel. Bits 7:6 select the channel, bits 5:4 give the access (1 low byte only, 2 high byte only, 3 word), bits 3:1 give the counting mode and bit 0 the BCD flag. The mode and flag appear on mode_o and bcd_o, and the read and write byte pointers of that channel return to the low byte.
- R3: In low-byte-only access a data write loads {8'h00, byte}; in high-byte-only access it loads {byte, 8'h00}. At most one channel's load strobe is active in any cycle, during the write cycle.
- R4: In word access the first data write is held without a load, and the second loads {second, first} and returns the write pointer to the low byte.
- R5: A control word with access field 0 freezes the selected channel's live count, only if no count snapshot is held; a repeated freeze leaves the earlier snapshot unchanged.
- R6: Channel select 3 is a read-back command: bits 1, 2 and 3 choose channels 0, 1 and 2; bit 5 low requests a count snapshot and bit 4 low a status snapshot for each chosen channel.
- R7: A status snapshot is taken only if none is held and is {output level, 1'b0, access[1:0], mode[2:0], BCD}.
- R8: A read returns a held status byte first and clears it. It then returns a held count snapshot, which is released after its last byte (low, high, or low then high for word access). Only after that does it return live count bytes in the channel's access mode.
- R9: A live read in word access alternates low and high byte on successive reads, independently of the write pointer.
- R10: A read of address 3 returns 8'h00 and changes no channel state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe, ignored during a write |
| addr_i | input | 2 | 0 to 2 channel data, 3 control |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, valid while rd_en_i is high |
| cnt_i | input | 48 | Live count of each channel, channel n at bits 16n+15:16n |
| out_i | input | 3 | Output level of each channel |
| load_o | output | 3 | Load strobe per channel |
| load_val_o | output | 48 | Load value per channel, channel n at bits 16n+15:16n |
| mode_o | output | 9 | Counting mode per channel, channel n at bits 3n+2:3n |
| bcd_o | output | 3 | BCD flag per channel |

## Verification
The in-line assertions watch, on every cycle, that a held status or count snapshot stays frozen until a read consumes it, that a status read clears the status, that reprogramming zeroes both byte pointers, that a held low byte arms the second word write, and that no two channels load together. Only the scenarios can show the byte values returned across a mix of snapshot precedence, read-back subsets, live word alternation and address-3 reads, and the load values that come out of each access mode. A reference model in the bench follows random sequences of control words, data writes and reads against a changing live count to cover these.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH  = 3;
  localparam int DW   = 8;
  localparam int CW   = 2 * DW;
  localparam int MW   = 3;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LSB  = 2'd1,
    ACC_MSB  = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;
endpackage

// File: rtl/tmr_ctrl_dec.sv
module tmr_ctrl_dec
  import tmr_pkg::*;
(
  input  logic           cw_valid_i,
  input  logic [DW-1:0]  cw_i,
  output logic [NCH-1:0] prog_o,
  output logic [NCH-1:0] lat_cnt_o,
  output logic [NCH-1:0] lat_sts_o,
  output acc_e           acc_o,
  output logic [MW-1:0]  mode_o,
  output logic           bcd_o
);
  logic [1:0] sel;

  assign sel    = cw_i[7:6];
  assign acc_o  = acc_e'(cw_i[5:4]);
  assign mode_o = cw_i[3:1];
  assign bcd_o  = cw_i[0];

  always_comb begin
    prog_o    = '0;
    lat_cnt_o = '0;
    lat_sts_o = '0;
    if (cw_valid_i) begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (sel == 2'd3) begin
          // read-back: channel mask in bits 3:1, requests active low
          if (cw_i[1+ch]) begin
            lat_cnt_o[ch] = ~cw_i[5];
            lat_sts_o[ch] = ~cw_i[4];
          end
        end else if (sel == ch[1:0]) begin
          if (acc_o == ACC_NONE) lat_cnt_o[ch] = 1'b1;
          else                   prog_o[ch]    = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_chan_seq.sv
module tmr_chan_seq
  import tmr_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           prog_i,
  input  logic           lat_cnt_i,
  input  logic           lat_sts_i,
  input  acc_e           acc_i,
  input  logic [MW-1:0]  mode_i,
  input  logic           bcd_i,
  input  logic           dwr_i,
  input  logic           drd_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [CW-1:0]  cnt_i,
  input  logic           out_i,
  output logic           load_o,
  output logic [CW-1:0]  load_val_o,
  output logic [DW-1:0]  rdata_o,
  output logic [MW-1:0]  mode_o,
  output logic           bcd_o
);
  acc_e          acc_q;
  logic [MW-1:0] mode_q;
  logic          bcd_q;
  logic          wr_hi_q, rd_hi_q;
  logic [DW-1:0] wl_q;
  acc_e          cl_q;       // count snapshot release state, ACC_NONE = empty
  logic [CW-1:0] lc_q;
  logic          sts_v_q;
  logic [DW-1:0] sts_q;

  assign mode_o = mode_q;
  assign bcd_o  = bcd_q;

  assign load_o = dwr_i && ((acc_q != ACC_WORD) || wr_hi_q);

  always_comb begin
    unique case (acc_q)
      ACC_MSB:  load_val_o = {wdata_i, {DW{1'b0}}};
      ACC_WORD: load_val_o = {wdata_i, wl_q};
      default:  load_val_o = {{DW{1'b0}}, wdata_i};
    endcase
  end

  always_comb begin
    if (sts_v_q) begin
      rdata_o = sts_q;
    end else if (cl_q != ACC_NONE) begin
      rdata_o = (cl_q == ACC_MSB) ? lc_q[CW-1:DW] : lc_q[DW-1:0];
    end else begin
      unique case (acc_q)
        ACC_LSB: rdata_o = cnt_i[DW-1:0];
        ACC_MSB: rdata_o = cnt_i[CW-1:DW];
        default: rdata_o = rd_hi_q ? cnt_i[CW-1:DW] : cnt_i[DW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= ACC_WORD;
      mode_q  <= '0;
      bcd_q   <= 1'b0;
      wr_hi_q <= 1'b0;
      rd_hi_q <= 1'b0;
      wl_q    <= '0;
      cl_q    <= ACC_NONE;
      lc_q    <= '0;
      sts_v_q <= 1'b0;
      sts_q   <= '0;
    end else begin
      if (prog_i) begin
        acc_q   <= acc_i;
        mode_q  <= mode_i;
        bcd_q   <= bcd_i;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end
      if (dwr_i && acc_q == ACC_WORD) begin
        if (!wr_hi_q) wl_q <= wdata_i;
        wr_hi_q <= ~wr_hi_q;
      end
      if (lat_cnt_i && cl_q == ACC_NONE) begin
        lc_q <= cnt_i;
        cl_q <= acc_q;
      end
      if (lat_sts_i && !sts_v_q) begin
        sts_q   <= {out_i, 1'b0, acc_q, mode_q, bcd_q};
        sts_v_q <= 1'b1;
      end
      if (drd_i) begin
        if (sts_v_q)                sts_v_q <= 1'b0;
        else if (cl_q != ACC_NONE)  cl_q    <= (cl_q == ACC_WORD) ? ACC_MSB : ACC_NONE;
        else if (acc_q == ACC_WORD) rd_hi_q <= ~rd_hi_q;
      end
    end
  end

  assert_sts_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_v_q && !drd_i) |=> (sts_v_q && $stable(sts_q)));

  assert_sts_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_v_q && drd_i) |=> !sts_v_q);

  assert_cnt_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_q != ACC_NONE && !drd_i) |=> ($stable(lc_q) && $stable(cl_q)));

  assert_seq_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> (!wr_hi_q && !rd_hi_q));

  assert_word_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dwr_i && acc_q == ACC_WORD && !wr_hi_q && !prog_i) |=> wr_hi_q);
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [1:0]         addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [NCH*CW-1:0]  cnt_i,
  input  logic [NCH-1:0]     out_i,
  output logic [NCH-1:0]     load_o,
  output logic [NCH*CW-1:0]  load_val_o,
  output logic [NCH*MW-1:0]  mode_o,
  output logic [NCH-1:0]     bcd_o
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic           cw_valid, rd_act;
  logic [NCH-1:0] prog, lat_cnt, lat_sts;
  acc_e           cw_acc;
  logic [MW-1:0]  cw_mode;
  logic           cw_bcd;
  logic [DW-1:0]  ch_rdata [NCH];

  assign cw_valid = wr_en_i && (addr_i == CTRL_ADDR);
  assign rd_act   = rd_en_i && !wr_en_i;

  tmr_ctrl_dec u_dec (
    .cw_valid_i (cw_valid),
    .cw_i       (wdata_i),
    .prog_o     (prog),
    .lat_cnt_o  (lat_cnt),
    .lat_sts_o  (lat_sts),
    .acc_o      (cw_acc),
    .mode_o     (cw_mode),
    .bcd_o      (cw_bcd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_chan_seq u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .prog_i     (prog[g]),
      .lat_cnt_i  (lat_cnt[g]),
      .lat_sts_i  (lat_sts[g]),
      .acc_i      (cw_acc),
      .mode_i     (cw_mode),
      .bcd_i      (cw_bcd),
      .dwr_i      (wr_en_i && addr_i == g[1:0]),
      .drd_i      (rd_act && addr_i == g[1:0]),
      .wdata_i    (wdata_i),
      .cnt_i      (cnt_i[g*CW +: CW]),
      .out_i      (out_i[g]),
      .load_o     (load_o[g]),
      .load_val_o (load_val_o[g*CW +: CW]),
      .rdata_o    (ch_rdata[g]),
      .mode_o     (mode_o[g*MW +: MW]),
      .bcd_o      (bcd_o[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int ch = 0; ch < NCH; ch++)
      if (rd_act && addr_i == ch[1:0]) rdata_o = ch_rdata[ch];
  end

  assert_load_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o));

  assert_load_needs_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o != '0) |-> (wr_en_i && addr_i != CTRL_ADDR));

  assert_ctrl_rd_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == CTRL_ADDR) |-> (rdata_o == '0));
endmodule

// File: tb/tmr_host_if_tb_top.sv
module tmr_host_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] cnt_bus;
  logic [2:0]  out_bus;
  logic [2:0]  load;
  logic [47:0] load_val;
  logic [8:0]  mode;
  logic [2:0]  bcd;

  logic [15:0] cnt_v [3];
  logic        out_v [3];

  // counter stub: bench-controlled live values, loads captured below
  assign cnt_bus = {cnt_v[2], cnt_v[1], cnt_v[0]};
  assign out_bus = {out_v[2], out_v[1], out_v[0]};
  logic [15:0] stub_loaded [3];
  always_ff @(posedge clk)
    for (int i = 0; i < 3; i++) if (load[i]) stub_loaded[i] <= load_val[i*16 +: 16];

  always #10 clk = ~clk;

  tmr_host_if dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .cnt_i(cnt_bus),
    .out_i(out_bus), .load_o(load), .load_val_o(load_val),
    .mode_o(mode), .bcd_o(bcd)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  logic [1:0]  m_acc [3];
  logic [2:0]  m_mode [3];
  logic        m_bcd [3];
  logic        m_whi [3], m_rhi [3];
  logic [7:0]  m_wl [3];
  logic [1:0]  m_cl [3];
  logic [15:0] m_lc [3];
  logic        m_sv [3];
  logic [7:0]  m_sts [3];

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  function automatic void m_lat_cnt(int ch);
    if (m_cl[ch] == 2'd0) begin m_lc[ch] = cnt_v[ch]; m_cl[ch] = m_acc[ch]; end
  endfunction

  function automatic void m_lat_sts(int ch);
    if (!m_sv[ch]) begin
      m_sts[ch] = {out_v[ch], 1'b0, m_acc[ch], m_mode[ch], m_bcd[ch]};
      m_sv[ch]  = 1'b1;
    end
  endfunction

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    logic [2:0]  exp_ld = '0;
    logic [15:0] exp_val = '0;
    string tag = "R3";
    int ch;
    int prg = -1;
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    #5;
    if (a != 2'd3) begin
      ch = int'(a);
      case (m_acc[ch])
        2'd1: begin exp_ld[ch] = 1'b1; exp_val = {8'h00, d}; end
        2'd2: begin exp_ld[ch] = 1'b1; exp_val = {d, 8'h00}; end
        default: begin
          tag = "R4";
          if (m_whi[ch]) begin exp_ld[ch] = 1'b1; exp_val = {d, m_wl[ch]}; end
        end
      endcase
      check(32'(load), 32'(exp_ld), tag);
      if (exp_ld != '0) check(32'(load_val[ch*16 +: 16]), 32'(exp_val), tag);
      if (m_acc[ch] == 2'd3) begin
        if (!m_whi[ch]) m_wl[ch] = d;
        m_whi[ch] = ~m_whi[ch];
      end
    end else begin
      check(32'(load), 32'd0, "R3");
      if (d[7:6] == 2'd3) begin
        for (int c = 0; c < 3; c++) if (d[1+c]) begin
          if (!d[5]) m_lat_cnt(c);
          if (!d[4]) m_lat_sts(c);
        end
      end else if (d[5:4] == 2'd0) begin
        m_lat_cnt(int'(d[7:6]));
      end else begin
        prg = int'(d[7:6]);
        m_acc[prg] = d[5:4]; m_mode[prg] = d[3:1]; m_bcd[prg] = d[0];
        m_whi[prg] = 1'b0; m_rhi[prg] = 1'b0;
      end
    end
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (prg >= 0) begin
      check(32'(mode[prg*3 +: 3]), 32'(m_mode[prg]), "R2");
      check(32'(bcd[prg]), 32'(m_bcd[prg]), "R2");
    end
  endtask

  task automatic do_rd(input logic [1:0] a, input string force_tag = "");
    logic [7:0] exp = '0;
    string tag = "R10";
    int ch;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #5;
    if (a != 2'd3) begin
      ch = int'(a);
      if (m_sv[ch]) begin
        exp = m_sts[ch]; tag = "R7"; m_sv[ch] = 1'b0;
      end else if (m_cl[ch] != 2'd0) begin
        exp = (m_cl[ch] == 2'd2) ? m_lc[ch][15:8] : m_lc[ch][7:0];
        tag = "R8";
        m_cl[ch] = (m_cl[ch] == 2'd3) ? 2'd2 : 2'd0;
      end else if (m_acc[ch] == 2'd3) begin
        exp = m_rhi[ch] ? cnt_v[ch][15:8] : cnt_v[ch][7:0];
        tag = "R9"; m_rhi[ch] = ~m_rhi[ch];
      end else begin
        exp = (m_acc[ch] == 2'd2) ? cnt_v[ch][15:8] : cnt_v[ch][7:0];
        tag = "R8";
      end
    end
    if (force_tag != "") tag = force_tag;
    check(32'(rdata), 32'(exp), tag);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) begin
      cnt_v[i] = 16'h1111 * 16'(i + 1); out_v[i] = 1'b0;
      m_acc[i] = 2'd3; m_mode[i] = '0; m_bcd[i] = 1'b0; m_whi[i] = 1'b0; m_rhi[i] = 1'b0;
      m_wl[i] = '0; m_cl[i] = '0; m_lc[i] = '0; m_sv[i] = 1'b0; m_sts[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    check(32'(load), 32'd0, "R1");
    check(32'(mode), 32'd0, "R1");
    check(32'(bcd), 32'd0, "R1");
    rst_n = 1'b1;
    // R1: word access after reset, low byte first
    do_rd(2'd0, "R1");
    do_rd(2'd0, "R1");

    // R5: repeat freeze keeps the first snapshot
    do_wr(2'd3, 8'b01_00_0000);
    cnt_v[1] = 16'hBEEF;
    do_wr(2'd3, 8'b01_00_0000);
    do_rd(2'd1, "R5");
    do_rd(2'd1, "R5");

    // R6: read-back of channels 0 and 2, count and status
    out_v[2] = 1'b1; cnt_v[2] = 16'hA55A;
    do_wr(2'd3, 8'b11_00_1010);
    do_rd(2'd2, "R6");
    do_rd(2'd2, "R6");
    do_rd(2'd2, "R6");
    do_rd(2'd1, "R6");

    // R3/R4: explicit loads
    do_wr(2'd3, 8'b00_01_0100);
    do_wr(2'd0, 8'h5C);
    do_wr(2'd3, 8'b00_10_0011);
    do_wr(2'd0, 8'hC5);
    do_wr(2'd3, 8'b10_11_0110);
    do_wr(2'd2, 8'h34);
    do_wr(2'd2, 8'h12);
    check(32'(stub_loaded[2]), 32'h1234, "R4");

    // R9: live word read alternates despite a pending word write
    do_wr(2'd2, 8'h77);
    do_rd(2'd2, "R9");
    do_rd(2'd2, "R9");
    do_rd(2'd3, "R10");

    for (int it = 0; it < 2000; it++) begin
      int op = int'($urandom % 10);
      logic [7:0] d = 8'($urandom);
      for (int c = 0; c < 3; c++) begin
        if ($urandom % 3 == 0) cnt_v[c] = 16'($urandom);
        if ($urandom % 4 == 0) out_v[c] = 1'($urandom);
      end
      if (op < 3)      do_wr(2'd3, d);
      else if (op < 5) do_wr(2'($urandom % 3), d);
      else             do_rd(2'($urandom % 4));
    end
    finish_run();
  end
endmodule